// File: doc/BRIEF.md
# Serial Channel with Infrared Pulse Encoding

This block is one asynchronous serial channel: a transmitter and a receiver sharing a baud tick generator. The tick runs at sixteen times the bit rate and comes from a 16-bit divisor, with one tick every `divisor+1` clocks. Characters enter through a valid/ready stream into a 64-entry transmit queue and are shifted out on `txd`. Characters recovered from `rxd` land in a 64-entry receive queue and leave through a second valid/ready stream. Each received character carries its parity and framing error flags.

Character width (5 to 8 bits), parity (none, even or odd) and stop count (one or two) are plain configuration inputs. They are expected to be stable while the line is busy. The user picks the divisor as the clock rate over sixteen times the baud rate, minus one, and should keep the total rate error under about 1.87 % so that mid-bit sampling stays inside the bit.

With `irMode` set, the line is encoded as infrared pulses. The pin idles low. A zero bit becomes a high pulse of 3/16 of a bit time at the start of the bit, and a one bit sends nothing. The receiver takes such a pulse anywhere in a bit window as a zero.

Top module: `ir_uart_channel`

## Requirements
- R1: During and after reset, with no traffic, `txd` idles high in normal mode and low in infrared mode; `rxValid` and `overrun` are low and `txReady` is high.
- R2: One bit time lasts exactly 16*(divisor+1) clock cycles.
- R3: A transmitted frame is a low start bit, the data bits LSB first, an optional parity bit, then one stop bit, or two when `twoStop`=1, driven high. `dataBits` selects the width as 0=5, 1=6, 2=7, 3=8 bits. Back-to-back frames are spaced by the frame length plus one tick.
- R4: The transmitted parity bit is the XOR of the used data bits, inverted when `parityOdd`=1; it is sent only when `parityEn`=1.
- R5: Received characters appear on `rxData` in arrival order, with the unused upper bits zero; `rxValid` holds the head entry steady until `rxReady` takes it.
- R6: A low on the line that has returned high by the middle of the start bit (the 8th sub-tick after detection) yields no character.
- R7: A stop bit sampled low sets `rxFrameErr` on that same character.
- R8: With parity enabled, a parity bit that disagrees with the received data sets `rxParityErr` on that character.
- R9: A character that completes while the receive queue holds 64 entries is dropped, and `overrun` pulses high for one cycle; the queued entries are unchanged.
- R10: In infrared mode, each zero bit (the start bit included) drives `txd` high for exactly 3*(divisor+1) cycles at the start of the bit; one bits and stop bits leave it low.
- R11: In infrared mode, the receiver decodes pulsed frames correctly, so a looped-back frame returns the sent character with no error flags.
- R12: The transmit queue holds 64 characters besides the one being shifted, and `txReady` falls when it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| divisor | input | DIV_W (16) | Sub-tick period minus one, in clocks |
| dataBits | input | 2 | Character width select: 0=5, 1=6, 2=7, 3=8 |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | Odd parity when 1, even when 0 |
| twoStop | input | 1 | Two stop bits on transmit |
| irMode | input | 1 | Infrared pulse encoding on both pins |
| txData | input | 8 | Character to send |
| txValid | input | 1 | `txData` is offered |
| txReady | output | 1 | Transmit queue has room |
| rxData | output | 8 | Received character, zero-extended |
| rxParityErr | output | 1 | Parity error for the head character |
| rxFrameErr | output | 1 | Stop bit was low for the head character |
| rxValid | output | 1 | Receive queue non-empty |
| rxReady | input | 1 | Consumer takes the head character |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| overrun | output | 1 | One-cycle pulse when a character is dropped |

## Verification
Most wrong internal states show up on `txd` within one bit time: a slipped sub-tick counter, a bit counter that stops early, or a lost stop-bit flag each stretch or shorten a measurable start bit, pulse or frame spacing by a whole number of ticks. A wrong receiver state, such as a sample point off centre, a shifter that is not cleared, or a stale infrared pulse flag, appears as the wrong character or flag at the head of the receive stream after one frame time. Queue pointer faults show only at the depth boundary. They are therefore provoked by filling both queues and checking `txReady`, the single `overrun` pulse and the exact drained sequence.

// File: rtl/iruc_pkg.sv
package iruc_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PARITY, PH_STOP} phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic   txPop;       // move queue head into the shifter
    logic   txShift;     // advance to next data bit
    phase_t txPhase;     // what the line carries now
    logic   txPulseWin;  // first 3 sub-ticks of the bit
    logic   rxStart;     // clear receive shifter and flags
    logic   rxCapture;   // store mid-bit sample at rxIdx
    logic [2:0] rxIdx;
    logic   rxParity;    // compare parity sample
    logic   rxStop;      // stop sample: push or overrun
    logic   rxWinClr;    // close infrared pulse window
  } strobe_t;
endpackage

// File: rtl/iruc_fifo.sv
module iruc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrEn,
  output logic             full,
  output logic [WIDTH-1:0] rdData,
  input  logic             rdEn,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] count;
  logic doWr, doRd;

  assign full   = count == (AW+1)'(DEPTH);
  assign empty  = count == '0;
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) if (doWr) mem[wrPtr] <= wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + AW'(1);
      if (doRd) rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + AW'(1);
      if (doWr && !doRd) count <= count + (AW+1)'(1);
      else if (doRd && !doWr) count <= count - (AW+1)'(1);
    end
  end
endmodule

// File: rtl/iruc_ctrl.sv
module iruc_ctrl import iruc_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       txAvail,
  input  logic       rxLvl,
  input  logic [1:0] dataBits,
  input  logic       parityEn,
  input  logic       twoStop,
  output strobe_t    stb
);
  phase_t txPh, rxPh;
  logic [3:0] txSub, rxSub;
  logic [2:0] txCnt, rxCnt, lastIdx;
  logic txStop2, rxMid, rxEnd;

  assign lastIdx = 3'd4 + {1'b0, dataBits};
  assign rxMid   = tick && rxPh != PH_IDLE && rxSub == 4'd7;
  assign rxEnd   = tick && rxPh != PH_IDLE && rxSub == 4'd15;

  always_comb begin
    stb = '0;
    stb.txPop      = tick && txPh == PH_IDLE && txAvail;
    stb.txShift    = tick && txPh == PH_DATA && txSub == 4'd15;
    stb.txPhase    = txPh;
    stb.txPulseWin = txSub < 4'd3;
    stb.rxStart    = tick && rxPh == PH_IDLE && !rxLvl;
    stb.rxCapture  = rxMid && rxPh == PH_DATA;
    stb.rxIdx      = rxCnt;
    stb.rxParity   = rxMid && rxPh == PH_PARITY;
    stb.rxStop     = rxMid && rxPh == PH_STOP;
    stb.rxWinClr   = rxEnd || (rxMid && rxPh == PH_START && rxLvl);
  end

  // transmit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPh <= PH_IDLE; txSub <= '0; txCnt <= '0; txStop2 <= 1'b0;
    end else if (tick) begin
      if (txPh == PH_IDLE) begin
        txSub <= '0;
        if (txAvail) txPh <= PH_START;
      end else begin
        txSub <= txSub + 4'd1;
        if (txSub == 4'd15) begin
          case (txPh)
            PH_START:  begin txPh <= PH_DATA; txCnt <= '0; end
            PH_DATA:   if (txCnt == lastIdx) txPh <= parityEn ? PH_PARITY : PH_STOP;
                       else txCnt <= txCnt + 3'd1;
            PH_PARITY: txPh <= PH_STOP;
            default:   if (twoStop && !txStop2) txStop2 <= 1'b1;
                       else begin txStop2 <= 1'b0; txPh <= PH_IDLE; end
          endcase
        end
      end
    end
  end

  // receive sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPh <= PH_IDLE; rxSub <= '0; rxCnt <= '0;
    end else if (tick) begin
      if (rxPh == PH_IDLE) begin
        rxSub <= '0;
        if (!rxLvl) rxPh <= PH_START;
      end else begin
        rxSub <= rxSub + 4'd1;
        if (rxSub == 4'd7 && (rxPh == PH_STOP || (rxPh == PH_START && rxLvl)))
          rxPh <= PH_IDLE;
        else if (rxSub == 4'd15) begin
          case (rxPh)
            PH_START:  begin rxPh <= PH_DATA; rxCnt <= '0; end
            PH_DATA:   if (rxCnt == lastIdx) rxPh <= parityEn ? PH_PARITY : PH_STOP;
                       else rxCnt <= rxCnt + 3'd1;
            PH_PARITY: rxPh <= PH_STOP;
            default:   rxPh <= PH_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/iruc_datapath.sv
module iruc_datapath import iruc_pkg::*; #(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        dataBits,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              irMode,
  input  strobe_t           stb,
  input  logic [CHAR_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [CHAR_W-1:0] rxData,
  output logic              rxParityErr,
  output logic              rxFrameErr,
  output logic              rxValid,
  input  logic              rxReady,
  output logic              txd,
  input  logic              rxd,
  output logic              overrun,
  output logic              tick,
  output logic              txAvail,
  output logic              rxLvl
);
  localparam int RXW = CHAR_W + 2;

  logic [DIV_W-1:0] divCnt;
  logic [CHAR_W-1:0] dataMask, txHead, txSh, rxSh;
  logic txFull, txEmpty, rxFull, rxEmpty, txPar, lvl, txAct, rxParBad, irSeen, act;
  logic [1:0] actSync;
  logic [RXW-1:0] rxEntry, rxHead;

  assign tick     = divCnt == divisor;
  assign dataMask = 8'hFF >> (2'd3 - dataBits);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) divCnt <= '0;
    else divCnt <= tick ? '0 : divCnt + DIV_W'(1);

  // transmit side
  iruc_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) txQ (
    .clk, .rstN, .wrData(txData), .wrEn(txValid), .full(txFull),
    .rdData(txHead), .rdEn(stb.txPop), .empty(txEmpty));
  assign txReady = !txFull;
  assign txAvail = !txEmpty;

  always_comb
    case (stb.txPhase)
      PH_START:  lvl = 1'b0;
      PH_DATA:   lvl = txSh[0];
      PH_PARITY: lvl = txPar;
      default:   lvl = 1'b1;
    endcase

  // txAct is the "line active" level: low in normal mode, pulse in infrared
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0; txPar <= 1'b0; txAct <= 1'b0;
    end else begin
      if (stb.txPop) begin
        txSh  <= txHead & dataMask;
        txPar <= ^(txHead & dataMask) ^ parityOdd;
      end else if (stb.txShift) txSh <= txSh >> 1;
      txAct <= irMode ? (!lvl && stb.txPulseWin) : !lvl;
    end
  end
  assign txd = irMode ? txAct : !txAct;

  // receive side
  assign act   = actSync[1];
  assign rxLvl = !(act || irSeen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSync <= '0; irSeen <= 1'b0; rxSh <= '0; rxParBad <= 1'b0; overrun <= 1'b0;
    end else begin
      actSync <= {actSync[0], irMode ? rxd : !rxd};
      irSeen  <= stb.rxWinClr ? 1'b0 : (irSeen || (irMode && act));
      if (stb.rxStart) begin
        rxSh <= '0; rxParBad <= 1'b0;
      end
      if (stb.rxCapture) rxSh[stb.rxIdx] <= rxLvl;
      if (stb.rxParity) rxParBad <= (^rxSh) ^ parityOdd ^ rxLvl;
      overrun <= stb.rxStop && rxFull;
    end
  end

  assign rxEntry = {rxParBad && parityEn, !rxLvl, rxSh};

  iruc_fifo #(.WIDTH(RXW), .DEPTH(FIFO_DEPTH)) rxQ (
    .clk, .rstN, .wrData(rxEntry), .wrEn(stb.rxStop), .full(rxFull),
    .rdData(rxHead), .rdEn(rxReady), .empty(rxEmpty));
  assign rxValid     = !rxEmpty;
  assign rxData      = rxHead[CHAR_W-1:0];
  assign rxFrameErr  = rxHead[CHAR_W];
  assign rxParityErr = rxHead[CHAR_W+1];
endmodule

// File: rtl/ir_uart_channel.sv
module ir_uart_channel import iruc_pkg::*; #(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       dataBits,
  input  logic             parityEn,
  input  logic             parityOdd,
  input  logic             twoStop,
  input  logic             irMode,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic [7:0]       rxData,
  output logic             rxParityErr,
  output logic             rxFrameErr,
  output logic             rxValid,
  input  logic             rxReady,
  output logic             txd,
  input  logic             rxd,
  output logic             overrun
);
  strobe_t stb;
  logic tick, txAvail, rxLvl;

  iruc_ctrl ctrl (
    .clk, .rstN, .tick, .txAvail, .rxLvl, .dataBits, .parityEn, .twoStop, .stb);

  iruc_datapath #(.DIV_W(DIV_W), .FIFO_DEPTH(FIFO_DEPTH)) dp (
    .clk, .rstN, .divisor, .dataBits, .parityEn, .parityOdd, .irMode, .stb,
    .txData, .txValid, .txReady, .rxData, .rxParityErr, .rxFrameErr, .rxValid,
    .rxReady, .txd, .rxd, .overrun, .tick, .txAvail, .rxLvl);
endmodule

// File: rtl/ir_uart_channel_chk.sv
module ir_uart_channel_chk (
  input logic       clk,
  input logic       rstN,
  input logic       irMode,
  input logic       txd,
  input logic       rxValid,
  input logic       rxReady,
  input logic [7:0] rxData,
  input logic       overrun
);
  // R9
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> rxValid);

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxReady |=> rxValid && $stable(rxData));

  // R10
  ir_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irMode && $rose(txd) |=> txd);

  // R3
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irMode && $fell(txd) |=> !txd);
endmodule

bind ir_uart_channel ir_uart_channel_chk chk_i (.*);

// File: tb/tb_ir_uart_channel.sv
module tb_ir_uart_channel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] divisor;
  logic [1:0]  dataBits;
  logic parityEn, parityOdd, twoStop, irMode;
  logic [7:0] txData, rxData;
  logic txValid, txReady, rxParityErr, rxFrameErr, rxValid, rxReady;
  logic txd, rxd, benchRxd, loopBack, overrun;
  int checks = 0, fails = 0, ovCount = 0, bitT = 32;

  assign rxd = loopBack ? txd : benchRxd;

  ir_uart_channel dut (.*);

  always @(negedge clk) if (rstN && overrun) ovCount++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int dv, input int nb, input bit pe, input bit po,
                     input bit ts, input bit ir, input bit lb);
    rstN = 1'b0;
    divisor = 16'(dv); dataBits = 2'(nb - 5); parityEn = pe; parityOdd = po;
    twoStop = ts; irMode = ir; loopBack = lb; txValid = 1'b0; txData = '0;
    rxReady = 1'b0; benchRxd = !ir; bitT = 16 * (dv + 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic parOf(input logic [7:0] d, input int n, input bit odd);
    logic [7:0] m = 8'hFF >> (8 - n);
    return ^(d & m) ^ odd;
  endfunction

  task automatic pushTx(input logic [7:0] b);
    while (!txReady) @(negedge clk);
    txValid = 1'b1; txData = b;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic popRx(output logic [7:0] d, output logic pe, output logic fe, output bit got);
    got = 0; d = '0; pe = 0; fe = 0;
    for (int i = 0; i < 30 * bitT; i++) begin
      if (rxValid) begin got = 1; break; end
      @(negedge clk);
    end
    if (got) begin
      d = rxData; pe = rxParityErr; fe = rxFrameErr;
      rxReady = 1'b1;
      @(negedge clk);
      rxReady = 1'b0;
    end
  endtask

  task automatic waitTxd(input logic lvl);
    for (int i = 0; i < 40 * bitT; i++) begin
      if (txd == lvl) break;
      @(negedge clk);
    end
  endtask

  task automatic captureTx(input int n, input bit hasPar, output logic [7:0] d,
                           output logic p, output logic s);
    d = '0; p = 0;
    waitTxd(1'b0);
    repeat (bitT / 2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      repeat (bitT) @(negedge clk);
      d[k] = txd;
    end
    if (hasPar) begin repeat (bitT) @(negedge clk); p = txd; end
    repeat (bitT) @(negedge clk);
    s = txd;
  endtask

  task automatic driveFrame(input logic [7:0] d, input int n, input bit withPar,
                            input logic parVal, input bit stopLow);
    benchRxd = 1'b0;
    repeat (bitT) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      benchRxd = d[k];
      repeat (bitT) @(negedge clk);
    end
    if (withPar) begin benchRxd = parVal; repeat (bitT) @(negedge clk); end
    if (stopLow) begin benchRxd = 1'b0; repeat (bitT * 5 / 8) @(negedge clk); end
    benchRxd = 1'b1;
    repeat (bitT) @(negedge clk);
  endtask

  task automatic testReset();
    cfg(1, 8, 0, 0, 0, 0, 0);
    chk("R1 txd idle high", txd, 1);
    chk("R1 rxValid low", rxValid, 0);
    chk("R1 txReady high", txReady, 1);
    chk("R1 overrun low", overrun, 0);
  endtask

  task automatic testTxFrame();
    logic [7:0] d; logic p, s; int n;
    cfg(3, 8, 0, 0, 0, 0, 0);
    pushTx(8'hA5);
    waitTxd(1'b0);
    n = 0;
    while (txd == 1'b0 && n < 10000) begin @(negedge clk); n++; end
    chk("R2 start bit length div=3", n, 64);
    cfg(1, 8, 0, 0, 0, 0, 0);
    pushTx(8'h3C);
    captureTx(8, 0, d, p, s);
    chk("R3 8N1 data LSB first", d, 8'h3C);
    chk("R3 stop bit high", s, 1);
    cfg(1, 7, 1, 0, 0, 0, 0);
    pushTx(8'h35);
    captureTx(7, 1, d, p, s);
    chk("R3 7-bit data", d, 8'h35);
    chk("R4 even parity", p, parOf(8'h35, 7, 0));
    cfg(1, 7, 1, 1, 0, 0, 0);
    pushTx(8'h35);
    captureTx(7, 1, d, p, s);
    chk("R4 odd parity", p, parOf(8'h35, 7, 1));
    // two stop bits: spacing of back-to-back 5-bit frames
    cfg(1, 5, 0, 0, 1, 0, 0);
    pushTx(8'h1F);
    pushTx(8'h1F);
    waitTxd(1'b0);
    n = 0;
    do begin @(negedge clk); n++; end while (txd == 1'b0 && n < 10000);
    do begin @(negedge clk); n++; end while (txd == 1'b1 && n < 10000);
    chk("R3 5-bit two-stop frame spacing", n, 8 * 32 + 2);
  endtask

  task automatic testLoop();
    logic [7:0] d; logic pe, fe; bit got;
    logic [7:0] vals [3] = '{8'h00, 8'hFF, 8'h5A};
    cfg(1, 8, 0, 0, 0, 0, 1);
    foreach (vals[i]) pushTx(vals[i]);
    foreach (vals[i]) begin
      popRx(d, pe, fe, got);
      chk("R5 in-order receive", got ? int'(d) : -1, vals[i]);
      chk("R5 no flags", {pe, fe}, 0);
    end
    cfg(1, 5, 1, 0, 0, 0, 1);
    pushTx(8'hE3);
    popRx(d, pe, fe, got);
    chk("R5 5-bit upper bits zero", got ? int'(d) : -1, 8'h03);
    chk("R8 matching parity no error", pe, 0);
    cfg(1, 6, 1, 1, 1, 0, 1);
    pushTx(8'h2A);
    popRx(d, pe, fe, got);
    chk("R5 6-bit odd two-stop", got ? int'(d) : -1, 8'h2A);
  endtask

  task automatic testRxErrors();
    logic [7:0] d; logic pe, fe; bit got;
    cfg(1, 8, 0, 0, 0, 0, 0);
    benchRxd = 1'b0;
    repeat (8) @(negedge clk);
    benchRxd = 1'b1;
    repeat (3 * bitT) @(negedge clk);
    chk("R6 short low ignored", rxValid, 0);
    driveFrame(8'h3C, 8, 0, 0, 0);
    popRx(d, pe, fe, got);
    chk("R6 next frame received", got ? int'(d) : -1, 8'h3C);
    driveFrame(8'h55, 8, 0, 0, 1);
    popRx(d, pe, fe, got);
    chk("R7 data with frame error", got ? int'(d) : -1, 8'h55);
    chk("R7 frame error flag", fe, 1);
    driveFrame(8'h66, 8, 0, 0, 0);
    popRx(d, pe, fe, got);
    chk("R7 clean frame after error", got ? int'({fe, d}) : -1, 8'h66);
    chk("R7 no spurious character", rxValid, 0);
    cfg(1, 8, 1, 0, 0, 0, 0);
    driveFrame(8'h01, 8, 1, !parOf(8'h01, 8, 0), 0);
    popRx(d, pe, fe, got);
    chk("R8 parity error flag", got ? int'(pe) : -1, 1);
    driveFrame(8'h01, 8, 1, parOf(8'h01, 8, 0), 0);
    popRx(d, pe, fe, got);
    chk("R8 correct parity", got ? int'({pe, d}) : -1, 8'h01);
  endtask

  task automatic testInfrared();
    logic [7:0] d; logic pe, fe; bit got; int n, rises; logic prev;
    cfg(3, 8, 0, 0, 0, 1, 1);
    chk("R1 infrared idle low", txd, 0);
    pushTx(8'h0F);
    waitTxd(1'b1);
    n = 0; rises = 1; prev = 1'b1;
    for (int i = 0; i < 10 * bitT; i++) begin
      @(negedge clk);
      if (txd && n == i) n++;
      if (txd && !prev) rises++;
      prev = txd;
    end
    chk("R10 pulse width 3 sub-ticks", n + 1, 12);
    chk("R10 one pulse per zero bit", rises, 5);
    popRx(d, pe, fe, got);
    chk("R11 infrared loopback", got ? int'({pe, fe, d}) : -1, 8'h0F);
    cfg(1, 8, 1, 1, 0, 1, 1);
    pushTx(8'h81);
    popRx(d, pe, fe, got);
    chk("R11 infrared odd parity loopback", got ? int'({pe, fe, d}) : -1, 8'h81);
  endtask

  task automatic testDepth();
    logic [7:0] d; logic pe, fe; bit got; int bad;
    cfg(1, 8, 0, 0, 0, 0, 1);
    ovCount = 0;
    for (int i = 0; i < 65; i++) pushTx(8'(i));
    chk("R12 transmit queue full", txReady, 0);
    repeat (66 * (10 * bitT + 2)) @(negedge clk);
    chk("R9 single overrun pulse", ovCount, 1);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      popRx(d, pe, fe, got);
      if (!got || d != 8'(i)) bad++;
    end
    chk("R9 queued entries intact", bad, 0);
    chk("R9 dropped character absent", rxValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testTxFrame();
    testLoop();
    testRxErrors();
    testInfrared();
    testDepth();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule